// File: doc/BRIEF.md
# DMA Width and Endian Packer

This block sits inside one DMA channel, between the side that reads from the source and the side that writes to the destination. Both sides use a 32-bit data bus. Each side has its own beat size (byte, halfword or word) and its own byte order. Every source beat is broken into bytes in ascending address order and appended to a small internal byte queue. Destination beats are built from the head of that queue. Narrow source beats are therefore packed into wider destination beats, and wide source beats are split into narrower ones. When the two sides use different byte orders, word data comes out byte-swapped.

Each side has a valid/ready handshake. The requester also supplies the two low address bits of each beat, because on a 32-bit bus those bits select the byte lanes for narrow beats. At the end of a transfer, a flush level lets the block drain a tail that is shorter than one destination beat. The tail leaves as beats of the largest size that fits. The number of bytes currently held is always visible on an output.

Top module: `dma_byte_packer`

## Requirements
- R1: A synchronous active-high reset empties the queue: `level` reads 0 and `out_valid` is low in the first cycle after reset.
- R2: Size codes are 0 for 8 bits, 1 for 16 bits and 2 (or 3) for 32 bits. Each source beat is aligned down to its own size using the address bits below that size. The byte at aligned address a+k is taken from lane a+k when `src_big` is 0, or from lane 3-(a+k) when `src_big` is 1. Lane n occupies bits 8n+7:8n.
- R3: A destination beat carries the oldest queued bytes in address order. The aligned destination address is used, and lanes are chosen by the same rule applied to `dst_big`.
- R4: When the source beat is narrower than the destination beat, consecutive source beats are packed in arrival order.
- R5: When the source beat is wider than the destination beat, it is split into consecutive destination beats in ascending address order.
- R6: A word sent from a little-endian source to a big-endian destination comes out with its four bytes reversed.
- R7: `in_ready` is high exactly when `flush` is low and `level` plus the source beat size does not exceed `BUF_BYTES`.
- R8: `out_valid` is high exactly when `level` is at least the destination beat size, or when `flush` is high and `level` is nonzero.
- R9: `out_size` gives the size of the offered beat. This is the destination size when enough bytes are held. Otherwise it is 16 bits if at least two bytes are held, and 8 bits if fewer. Flushing therefore ends with `level` at 0 and `out_valid` low.
- R10: `level` never exceeds `BUF_BYTES`. From one cycle to the next it changes by the bytes accepted minus the bytes delivered.
- R11: `out_strb` has exactly one bit set for each lane of the offered beat, and data lanes that are not strobed read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_size | input | 2 | Source beat size code |
| src_big | input | 1 | Source byte order: 1 big-endian |
| src_addr | input | 2 | Low address bits of the source beat |
| in_valid | input | 1 | Source beat offered |
| in_ready | output | 1 | Room for one full source beat |
| in_data | input | 32 | Source bus data |
| dst_size | input | 2 | Destination beat size code |
| dst_big | input | 1 | Destination byte order: 1 big-endian |
| dst_addr | input | 2 | Low address bits of the destination beat |
| flush | input | 1 | Drain a partial tail; blocks new input |
| out_valid | output | 1 | Destination beat offered |
| out_ready | input | 1 | Destination beat taken |
| out_data | output | 32 | Destination bus data |
| out_strb | output | 4 | Lanes carrying bytes |
| out_size | output | 2 | Size code of the offered beat |
| level | output | CNT_W | Bytes currently held |

## Verification
The bench uses the default `BUF_BYTES` of 8. With that depth, two word beats fill the queue. This makes the point where `in_ready` drops because of room, and the word-in/byte-out backlog, reachable within a few cycles of random handshakes. All nine source/destination size pairs are run with all four byte-order pairings. Each pairing ends with a flush, so tails of one, two and three bytes reach the downsizing path.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // number of bytes in a beat of the given size code
  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // align low address bits down to the beat size
  function automatic logic [1:0] align_addr(logic [1:0] a, logic [1:0] sz);
    case (sz)
      SZ_BYTE: return a;
      SZ_HALF: return {a[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  // lane carrying the byte at a given low address
  function automatic logic [1:0] lane_of(logic big, logic [1:0] byte_addr);
    return big ? ~byte_addr : byte_addr;
  endfunction

  // largest beat that fits in the bytes held, capped by the configured size
  function automatic logic [1:0] fit_size(int avail, logic [1:0] sz);
    if (avail >= int'(size_bytes(sz))) return (sz == 2'd3) ? SZ_WORD : sz;
    else if (avail >= 2)              return SZ_HALF;
    else                              return SZ_BYTE;
  endfunction
endpackage

// File: rtl/dbp_lane_unpack.sv
module dbp_lane_unpack
  import dbp_pkg::*;
(
  input  logic [DATA_W-1:0]     bus_data,
  input  logic [1:0]            sz,
  input  logic                  big,
  input  logic [1:0]            addr,
  output logic [LANES-1:0][7:0] bytes_o,
  output logic [2:0]            nbytes_o
);
  logic [1:0] base;

  assign base     = align_addr(addr, sz);
  assign nbytes_o = size_bytes(sz);

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [1:0] ln;
    assign ln         = lane_of(big, base + 2'(k));
    assign bytes_o[k] = bus_data[{ln, 3'b000} +: 8];
  end
endmodule

// File: rtl/dbp_lane_pack.sv
module dbp_lane_pack
  import dbp_pkg::*;
(
  input  logic [LANES-1:0][7:0] bytes_i,
  input  logic [1:0]            sz,
  input  logic                  big,
  input  logic [1:0]            addr,
  output logic [DATA_W-1:0]     data_o,
  output logic [LANES-1:0]      strb_o
);
  logic [1:0] base;
  logic [2:0] nb;
  logic [1:0] ln;

  assign base = align_addr(addr, sz);
  assign nb   = size_bytes(sz);

  always_comb begin
    data_o = '0;
    strb_o = '0;
    ln     = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(nb)) begin
        ln = lane_of(big, base + 2'(k));
        data_o[{ln, 3'b000} +: 8] = bytes_i[k];
        strb_o[ln] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbp_byte_fifo.sv
module dbp_byte_fifo
  import dbp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            push_n,
  input  logic [LANES-1:0][7:0] push_bytes,
  input  logic [2:0]            pop_n,
  output logic [LANES-1:0][7:0] head,
  output logic [CNT_W-1:0]      count
);
  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       mem_d [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  // shift out the popped bytes, then append the pushed ones after the survivors
  always_comb begin
    int base;
    base = int'(count_q) - int'(pop_n);
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n) < DEPTH) mem_d[i] = mem_q[i + int'(pop_n)];
      else                         mem_d[i] = '0;
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(push_n) && base + k == i) mem_d[i] = push_bytes[k];
      end
    end
  end

  assign count_d = count_q + CNT_W'(push_n) - CNT_W'(pop_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      count_q <= count_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_head
    assign head[k] = mem_q[k];
  end

  assign count = count_q;
endmodule

// File: rtl/dma_byte_packer.sv
module dma_byte_packer
  import dbp_pkg::*;
#(
  parameter  int BUF_BYTES = 8,
  localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        src_size,
  input  logic              src_big,
  input  logic [1:0]        src_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        dst_size,
  input  logic              dst_big,
  input  logic [1:0]        dst_addr,
  input  logic              flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_strb,
  output logic [1:0]        out_size,
  output logic [CNT_W-1:0]  level
);
  logic [LANES-1:0][7:0] src_bytes;
  logic [LANES-1:0][7:0] head_bytes;
  logic [2:0]            src_n;
  logic [2:0]            dst_n;
  logic                  room_ok;
  logic                  full_beat;
  // named events for the checker
  logic                  push_fire;
  logic                  pop_fire;
  logic [2:0]            push_n;
  logic [2:0]            pop_n;

  dbp_lane_unpack u_unpack (
    .bus_data (in_data),
    .sz       (src_size),
    .big      (src_big),
    .addr     (src_addr),
    .bytes_o  (src_bytes),
    .nbytes_o (src_n)
  );

  assign dst_n     = size_bytes(dst_size);
  assign room_ok   = (int'(level) + int'(src_n)) <= BUF_BYTES;
  assign full_beat = int'(level) >= int'(dst_n);

  assign in_ready  = !flush && room_ok;
  assign out_valid = full_beat || (flush && (level != '0));
  assign out_size  = fit_size(int'(level), dst_size);

  assign push_fire = in_valid && in_ready;
  assign pop_fire  = out_valid && out_ready;
  assign push_n    = push_fire ? src_n : 3'd0;
  assign pop_n     = pop_fire ? size_bytes(out_size) : 3'd0;

  dbp_byte_fifo #(
    .DEPTH (BUF_BYTES),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push_n     (push_n),
    .push_bytes (src_bytes),
    .pop_n      (pop_n),
    .head       (head_bytes),
    .count      (level)
  );

  dbp_lane_pack u_pack (
    .bytes_i (head_bytes),
    .sz      (out_size),
    .big     (dst_big),
    .addr    (dst_addr),
    .data_o  (out_data),
    .strb_o  (out_strb)
  );
endmodule

// File: rtl/dbp_checker.sv
module dbp_checker
  import dbp_pkg::*;
#(
  parameter  int BUF_BYTES = 8,
  localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             in_ready,
  input logic             out_valid,
  input logic [LANES-1:0] out_strb,
  input logic [1:0]       out_size,
  input logic [1:0]       dst_size,
  input logic [CNT_W-1:0] level,
  input logic [2:0]       push_n,
  input logic [2:0]       pop_n
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (level == '0 && !out_valid));

  assert_flush_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);

  assert_valid_cause_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(level) >= int'(size_bytes(dst_size)) || (flush && level != '0)));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (flush && level == '0) |-> !out_valid);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= BUF_BYTES);

  assert_level_step_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> int'(level) == int'($past(level)) + int'($past(push_n)) - int'($past(pop_n)));

  assert_strb_count_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_strb) == int'(size_bytes(out_size)));
endmodule

bind dma_byte_packer dbp_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_strb  (out_strb),
  .out_size  (out_size),
  .dst_size  (dst_size),
  .level     (level),
  .push_n    (push_n),
  .pop_n     (pop_n)
);

// File: tb/dma_byte_packer_tb.sv
module dma_byte_packer_tb;
  localparam int BUF = 8;
  localparam int CW  = $clog2(BUF + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst;
  logic [1:0]    src_size, dst_size, src_addr, dst_addr, out_size;
  logic          src_big, dst_big, in_valid, in_ready, flush, out_valid, out_ready;
  logic [31:0]   in_data, out_data;
  logic [3:0]    out_strb;
  logic [CW-1:0] level;

  dma_byte_packer #(.BUF_BYTES(BUF)) u_dut (
    .clk(clk), .rst(rst), .src_size(src_size), .src_big(src_big), .src_addr(src_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .dst_size(dst_size), .dst_big(dst_big), .dst_addr(dst_addr), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_strb(out_strb), .out_size(out_size), .level(level)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [7:0] q[$];   // reference byte stream
  int src_ofs = 0;
  int dst_ofs = 0;

  function automatic int nbytes(logic [1:0] code);
    if (code == 2'd0) return 1;
    if (code == 2'd1) return 2;
    return 4;
  endfunction

  function automatic logic [1:0] code_of(int n);
    return (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // compare against the queue model, update it, advance to the next drive point
  task automatic step();
    int ns, nd, held, nout, al;
    bit e_ready, e_valid;
    logic [31:0] e_data;
    logic [3:0]  e_strb;
    string tag;
    #1;
    ns = nbytes(src_size);
    nd = nbytes(dst_size);
    held = q.size();
    e_ready = !flush && (held + ns <= BUF);
    e_valid = (held >= nd) || (flush && held > 0);
    nout = (held >= nd) ? nd : ((held >= 2) ? 2 : 1);
    check("R10 level", 32'(level), 32'(held));
    check("R7 in_ready", 32'(in_ready), 32'(e_ready));
    check("R8 out_valid", 32'(out_valid), 32'(e_valid));
    if (e_valid) begin
      e_data = '0;
      e_strb = '0;
      al = dst_ofs - (dst_ofs % nout);
      for (int k = 0; k < nout; k++) begin
        int b, ln;
        b  = al + k;
        ln = dst_big ? 3 - b : b;
        e_data[ln*8 +: 8] = q[k];
        e_strb[ln] = 1'b1;
      end
      tag = (ns < nd) ? "R4 packed data" : (ns > nd) ? "R5 split data" : "R3 data";
      check(tag, out_data, e_data);
      check("R11 strobe", 32'(out_strb), 32'(e_strb));
      check("R9 size", 32'(out_size), 32'(code_of(nout)));
    end
    if (e_valid && out_ready) begin
      for (int k = 0; k < nout; k++) void'(q.pop_front());
      dst_ofs = (dst_ofs + nout) % 4;
    end
    if (in_valid && e_ready) begin
      al = src_ofs - (src_ofs % ns);
      for (int k = 0; k < ns; k++) begin
        int b, ln;
        b  = al + k;
        ln = src_big ? 3 - b : b;   // R2 lane rule
        q.push_back(in_data[ln*8 +: 8]);
      end
      src_ofs = (src_ofs + ns) % 4;
    end
    @(negedge clk);
    src_addr = 2'(src_ofs);
    dst_addr = 2'(dst_ofs);
  endtask

  task automatic setup(int sw, int dw, bit sb, bit db);
    src_size = 2'(sw); dst_size = 2'(dw);
    src_big = sb; dst_big = db;
    src_ofs = 0; dst_ofs = 0;
    src_addr = 2'd0; dst_addr = 2'd0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    flush    = 1'b1;
    for (int i = 0; i < 40 && q.size() > 0; i++) begin
      out_ready = ($urandom % 4) != 0;
      step();
    end
    out_ready = 1'b1;
    step();   // R9: empty after flush, nothing offered
    flush = 1'b0;
  endtask

  task automatic run_combo(int sw, int dw, bit sb, bit db);
    setup(sw, dw, sb, db);
    for (int i = 0; i < 50; i++) begin
      in_valid  = ($urandom % 10) < 7;
      out_ready = ($urandom % 10) < 6;
      in_data   = $urandom;
      step();
    end
    drain();
  endtask

  initial begin
    rst = 1'b1; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    setup(2, 2, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 level after reset", 32'(level), 32'd0);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    @(negedge clk);

    // R6: little-endian word in, big-endian word out
    setup(2, 2, 1'b0, 1'b1);
    in_valid = 1'b1; in_data = 32'h44332211; out_ready = 1'b0;
    step();
    in_valid = 1'b0; out_ready = 1'b1;
    #1 check("R6 mixed-endian swap", out_data, 32'h11223344);
    step();

    // R2: big-endian halfword source to little-endian halfword destination
    setup(1, 1, 1'b1, 1'b0);
    in_valid = 1'b1; in_data = 32'hAABB0000; out_ready = 1'b0;
    step();
    in_valid = 1'b0; out_ready = 1'b1;
    #1 check("R2 big-endian source lanes", out_data, 32'h0000BBAA);
    step();

    // R9: three-byte tail on a word destination leaves as half then byte
    setup(0, 2, 1'b0, 1'b0);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = 32'h01010101 * (i + 1);
      step();
    end
    in_valid = 1'b0; flush = 1'b1;
    #1 check("R9 first tail beat size", 32'(out_size), 32'd1);
    out_ready = 1'b1;
    step();
    #1 check("R9 second tail beat size", 32'(out_size), 32'd0);
    step();
    #1 check("R9 empty after flush", 32'(level), 32'd0);
    flush = 1'b0;
    step();

    // all size pairs and byte-order pairings (R3, R4, R5)
    for (int sw = 0; sw < 3; sw++)
      for (int dw = 0; dw < 3; dw++)
        for (int e = 0; e < 4; e++)
          run_combo(sw, dw, e[0], e[1]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule